// File: doc/BRIEF.md
# Timer Channel Clock Gate and Prescaler

This block turns three source clock strobes into a gated, divided clock strobe for each timer channel in a bank. The bank holds a parameter-set number of general timer channels (up to eight), one watchdog channel and, when a parameter asks for it, one free-running OS timer channel. Every channel has three settings. A stop bit gates its clock. A one-hot source field picks the peripheral, RTC or external strobe. A prescale code divides the chosen strobe by a power of four, from 1 up to 1024.

Software reaches the stop bits through three words. Writing a one to a bit of the stop-set word stops that channel. Writing a one to a bit of the stop-clear word starts it. The status word reads back the current stop bits. Each channel has its own control word, and that word only accepts writes while the channel is running. All source clocks are single-cycle enable strobes in the one system clock domain. Each channel output is a one-cycle strobe that later counters can use as their count enable.

Top module: `tmrclk_gate`

## Requirements
- R1: After reset every implemented stop bit is 1 and every control word reads 0. With the default parameters the status word reads 0x0001_80FF, and no channel strobe appears whatever the source strobes do.
- R2: A write to address 1 (stop-set) sets each implemented stop bit whose data bit is 1. Stop bits whose data bit is 0 keep their value.
- R3: A write to address 2 (stop-clear) clears each stop bit whose data bit is 1. Stop bits whose data bit is 0 keep their value.
- R4: Address 0 returns the stop bits: timer i at bit i, the OS timer at bit 15, the watchdog at bit 16. A 0 means running, and bits of absent channels read 0. When rd_en is low, rdata is 0.
- R5: The control words sit at address 8+i for timer i, 3 for the watchdog and 4 for the OS timer. Bits 2:0 hold the source select and bits 5:3 the prescale code. A read returns those six bits, and all higher bits read 0.
- R6: A control word write made while that channel's stop bit is 1 is ignored.
- R7: Source bit 0 selects the peripheral strobe, bit 1 the RTC strobe and bit 2 the external strobe. When several bits are set, the lowest set bit wins.
- R8: With no source bit set, a channel produces no strobe.
- R9: Prescale code n divides the selected strobe by 4^n for n from 0 to 5. Codes 6 and 7 divide by 1024.
- R10: A channel strobe is high for the one cycle after the clock edge that samples the N-th counted source strobe, where N is the divisor. A stopped channel produces no strobe and counts nothing.
- R11: A channel's divider restarts from zero when an accepted write changes its control word, and when its stop bit goes from 1 to 0. Strobes counted before the restart are discarded.
- R12: With HAS_OST = 0, bit 15 of the status word stays 0 under set and clear writes, and ost_tick stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| pclk_stb | input | 1 | Peripheral clock enable strobe |
| rtc_stb | input | 1 | RTC clock enable strobe |
| ext_stb | input | 1 | External clock enable strobe |
| tmr_tick | output | NUM_TMR | Divided strobe per timer channel |
| wdt_tick | output | 1 | Divided strobe of the watchdog channel |
| ost_tick | output | 1 | Divided strobe of the OS timer channel |

## Verification
The divider is driven with one strobe source at a time. Runs at divisors 1, 4, 16 and 1024 stop exactly one strobe short of the boundary and then one strobe past it, which separates an off-by-one in the terminal count from a correct divider. The source tests use mixed select fields with strobes on the unselected inputs, which tells a lowest-bit priority apart from a highest-bit one or from OR-ing the sources. The restart tests leave a partly filled divider before a control change or a stop and start, so a divider that keeps its old count fires early. Writes to locked control words, write-one masks with zeros, and a variant with no OS timer show that ignored accesses leave state untouched.

// File: rtl/tmrclk_pkg.sv
package tmrclk_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int STOP_W  = 17;
    localparam int CTRL_W  = 6;
    localparam int WDT_POS = 16;
    localparam int OST_POS = 15;
    localparam int MAX_TMR = 8;
    localparam int PRE_TOP = 5;
    localparam int CNT_W   = 2 * PRE_TOP;

    localparam logic [ADDR_W-1:0] A_STATUS   = 4'd0;
    localparam logic [ADDR_W-1:0] A_STOP_SET = 4'd1;
    localparam logic [ADDR_W-1:0] A_STOP_CLR = 4'd2;
    localparam logic [ADDR_W-1:0] A_WDT_CTRL = 4'd3;
    localparam logic [ADDR_W-1:0] A_OST_CTRL = 4'd4;
    localparam logic [ADDR_W-1:0] A_TMR_BASE = 4'd8;

    // Control word layout: prescale in 5:3, one-hot source in 2:0
    typedef struct packed {
        logic [2:0] pre;
        logic [2:0] src;
    } ctrl_t;

    typedef enum logic [1:0] {SRC_OFF, SRC_PCLK, SRC_RTC, SRC_EXT} src_t;

    // Lowest set bit of the select field wins
    function automatic src_t pick_src(input logic [2:0] s);
        if (s[0]) return SRC_PCLK;
        if (s[1]) return SRC_RTC;
        if (s[2]) return SRC_EXT;
        return SRC_OFF;
    endfunction

    // Terminal count 4^n - 1: n pairs of low ones, codes above PRE_TOP saturate
    function automatic logic [CNT_W-1:0] div_limit(input logic [2:0] pre);
        logic [2:0]       c;
        logic [CNT_W-1:0] lim;
        c   = (pre > 3'(PRE_TOP)) ? 3'(PRE_TOP) : pre;
        lim = '0;
        for (int k = 0; k < PRE_TOP; k++) begin
            if (k < int'(c)) lim[2*k +: 2] = 2'b11;
        end
        return lim;
    endfunction

    // Channel order: timers, then watchdog, then OS timer
    function automatic int stop_pos(input int ch, input int ntmr);
        if (ch < ntmr) return ch;
        if (ch == ntmr) return WDT_POS;
        return OST_POS;
    endfunction

    function automatic logic [ADDR_W-1:0] chan_addr(input int ch, input int ntmr);
        if (ch < ntmr) return A_TMR_BASE + ADDR_W'(ch);
        if (ch == ntmr) return A_WDT_CTRL;
        return A_OST_CTRL;
    endfunction

    function automatic logic [STOP_W-1:0] impl_mask(input int ntmr, input int has_ost);
        logic [STOP_W-1:0] m;
        m = '0;
        for (int k = 0; k < MAX_TMR; k++) begin
            if (k < ntmr) m[k] = 1'b1;
        end
        m[WDT_POS] = 1'b1;
        if (has_ost != 0) m[OST_POS] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/tmrclk_regs.sv
module tmrclk_regs
    import tmrclk_pkg::*;
#(
    parameter int NUM_TMR = 8,
    parameter int HAS_OST = 1,
    localparam int NCH    = NUM_TMR + 1 + HAS_OST
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NCH-1:0]      stop_ch,
    output ctrl_t [NCH-1:0]     ctrl_o,
    output logic [NCH-1:0]      restart_o
);
    localparam logic [STOP_W-1:0] MASK = impl_mask(NUM_TMR, HAS_OST);

    logic [STOP_W-1:0] stop_q;
    logic              set_hit;
    logic              clr_hit;
    logic              unused_hi;

    assign set_hit   = wr_en && (addr == A_STOP_SET);
    assign clr_hit   = wr_en && (addr == A_STOP_CLR);
    assign unused_hi = ^wdata[DATA_W-1:STOP_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= MASK;
        end else if (set_hit) begin
            stop_q <= (stop_q | wdata[STOP_W-1:0]) & MASK;
        end else if (clr_hit) begin
            stop_q <= stop_q & ~wdata[STOP_W-1:0];
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int                POS = stop_pos(ch, NUM_TMR);
        localparam logic [ADDR_W-1:0] ADR = chan_addr(ch, NUM_TMR);

        ctrl_t ctrl_q;
        ctrl_t nv;
        logic  acc;

        assign nv  = ctrl_t'(wdata[CTRL_W-1:0]);
        assign acc = wr_en && (addr == ADR) && !stop_q[POS];

        always_ff @(posedge clk) begin
            if (rst)      ctrl_q <= '0;
            else if (acc) ctrl_q <= nv;
        end

        assign stop_ch[ch]   = stop_q[POS];
        assign ctrl_o[ch]    = ctrl_q;
        assign restart_o[ch] = acc && (nv != ctrl_q);
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == A_STATUS) rdata[STOP_W-1:0] = stop_q;
            for (int ch = 0; ch < NCH; ch++) begin
                if (addr == chan_addr(ch, NUM_TMR)) rdata[CTRL_W-1:0] = ctrl_o[ch];
            end
        end
    end
endmodule

// File: rtl/tmrclk_div.sv
module tmrclk_div
    import tmrclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  restart,
    input  ctrl_t ctrl,
    input  logic  pclk_stb,
    input  logic  rtc_stb,
    input  logic  ext_stb,
    output logic  tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             stb;

    assign lim = div_limit(ctrl.pre);

    always_comb begin
        case (pick_src(ctrl.src))
            SRC_PCLK: stb = pclk_stb;
            SRC_RTC:  stb = rtc_stb;
            SRC_EXT:  stb = ext_stb;
            default:  stb = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (!run || restart) begin
                cnt <= '0;
            end else if (stb) begin
                if (cnt >= lim) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tmrclk_gate.sv
module tmrclk_gate
    import tmrclk_pkg::*;
#(
    parameter int NUM_TMR = 8,
    parameter int HAS_OST = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                pclk_stb,
    input  logic                rtc_stb,
    input  logic                ext_stb,
    output logic [NUM_TMR-1:0]  tmr_tick,
    output logic                wdt_tick,
    output logic                ost_tick
);
    localparam int NCH = NUM_TMR + 1 + HAS_OST;

    logic [NCH-1:0]  stop_ch;
    ctrl_t [NCH-1:0] ctrl_v;
    logic [NCH-1:0]  restart_v;
    logic [NCH-1:0]  tick_all;

    tmrclk_regs #(.NUM_TMR(NUM_TMR), .HAS_OST(HAS_OST)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .stop_ch   (stop_ch),
        .ctrl_o    (ctrl_v),
        .restart_o (restart_v)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_div
        tmrclk_div u_div (
            .clk      (clk),
            .rst      (rst),
            .run      (!stop_ch[ch]),
            .restart  (restart_v[ch]),
            .ctrl     (ctrl_v[ch]),
            .pclk_stb (pclk_stb),
            .rtc_stb  (rtc_stb),
            .ext_stb  (ext_stb),
            .tick     (tick_all[ch])
        );
    end

    assign tmr_tick = tick_all[NUM_TMR-1:0];
    assign wdt_tick = tick_all[NUM_TMR];

    if (HAS_OST != 0) begin : g_ost
        assign ost_tick = tick_all[NUM_TMR+1];
    end else begin : g_no_ost
        assign ost_tick = 1'b0;
    end
endmodule

// File: rtl/tmrclk_gate_checks.sv
module tmrclk_gate_checks
    import tmrclk_pkg::*;
#(
    parameter int NUM_TMR = 8,
    parameter int HAS_OST = 1,
    localparam int NCH    = NUM_TMR + 1 + HAS_OST
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic               wdata0,
    input logic [DATA_W-1:0]  rdata,
    input logic               pclk_stb,
    input logic               rtc_stb,
    input logic               ext_stb,
    input logic [NCH-1:0]     stop_ch,
    input logic [NCH-1:0]     tick_all
);
    // R1: all channels come out of reset stopped
    a_r1_reset_stopped: assert property (@(posedge clk)
        $fell(rst) |-> (&stop_ch));

    // R2: write-one to stop-set stops timer 0
    a_r2_set_stops: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_STOP_SET && wdata0) |=> stop_ch[0]);

    // R3: write-one to stop-clear starts timer 0
    a_r3_clr_starts: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_STOP_CLR && wdata0) |=> !stop_ch[0]);

    // R4: no read enable, no read data
    a_r4_idle_read: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0));

    // R8: without any source strobe nothing can be counted out
    a_r8_no_source_quiet: assert property (@(posedge clk) disable iff (rst)
        !(pclk_stb || rtc_stb || ext_stb) |=> (tick_all == '0));

    // R10: a stopped channel stays silent
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        a_r10_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
            stop_ch[ch] |=> !tick_all[ch]);
    end
endmodule

bind tmrclk_gate tmrclk_gate_checks #(.NUM_TMR(NUM_TMR), .HAS_OST(HAS_OST)) u_checks (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata0   (wdata[0]),
    .rdata    (rdata),
    .pclk_stb (pclk_stb),
    .rtc_stb  (rtc_stb),
    .ext_stb  (ext_stb),
    .stop_ch  (stop_ch),
    .tick_all (tick_all)
);

// File: tb/tmrclk_gate_test.sv
module tmrclk_gate_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        pclk_stb = 1'b0;
    logic        rtc_stb = 1'b0;
    logic        ext_stb = 1'b0;
    logic [31:0] rdata;
    logic [31:0] rdata_s;
    logic [7:0]  tmr_tick;
    logic        wdt_tick;
    logic        ost_tick;
    logic [5:0]  s_tick;
    logic        s_wdt;
    logic        s_ost;

    int n_chk = 0;
    int n_err = 0;
    int tc0 = 0, tall = 0, wc = 0, oc = 0, soc = 0;
    int b0 = 0, ball = 0, bw = 0, bo = 0;

    always #2 clk = ~clk;

    tmrclk_gate #(.NUM_TMR(8), .HAS_OST(1)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pclk_stb(pclk_stb), .rtc_stb(rtc_stb),
        .ext_stb(ext_stb), .tmr_tick(tmr_tick), .wdt_tick(wdt_tick), .ost_tick(ost_tick)
    );

    tmrclk_gate #(.NUM_TMR(6), .HAS_OST(0)) uut_small (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_s), .pclk_stb(pclk_stb), .rtc_stb(rtc_stb),
        .ext_stb(ext_stb), .tmr_tick(s_tick), .wdt_tick(s_wdt), .ost_tick(s_ost)
    );

    always @(negedge clk) begin
        if (!rst) begin
            tc0  += int'(tmr_tick[0]);
            tall += $countones({tmr_tick, wdt_tick, ost_tick});
            wc   += int'(wdt_tick);
            oc   += int'(ost_tick);
            soc  += int'(s_ost);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic [31:0] ds);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata; ds = rdata_s;
        rd_en = 1'b0;
    endtask

    // mask bit 0 = peripheral, bit 1 = RTC, bit 2 = external
    task automatic strobe(input logic [2:0] mask, input int n);
        @(negedge clk);
        {ext_stb, rtc_stb, pclk_stb} = mask;
        repeat (n) @(negedge clk);
        {ext_stb, rtc_stb, pclk_stb} = 3'b000;
        #1;
    endtask

    task automatic snap();
        b0 = tc0; ball = tall; bw = wc; bo = oc;
    endtask

    task automatic t_reset();
        logic [31:0] d, ds;
        rd(4'd0, d, ds);
        chk("R1 status after reset", d, 32'h0001_80FF);
        chk("R12 small status after reset", ds, 32'h0001_003F);
        rd(4'd8, d, ds);  chk("R1 timer0 ctrl after reset", d, 0);
        rd(4'd3, d, ds);  chk("R1 watchdog ctrl after reset", d, 0);
        rd(4'd4, d, ds);  chk("R1 OS timer ctrl after reset", d, 0);
        snap();
        strobe(3'b111, 8);
        chk("R1 no strobes while all stopped", 32'(tall - ball), 0);
    endtask

    task automatic t_locked();
        logic [31:0] d, ds;
        wr(4'd8, 32'h09);
        rd(4'd8, d, ds);
        chk("R6 write to stopped channel ignored", d, 0);
    endtask

    task automatic t_stopbits();
        logic [31:0] d, ds;
        wr(4'd2, 32'h9);
        rd(4'd0, d, ds); chk("R3 clear timers 0 and 3", d, 32'h0001_80F6);
        wr(4'd1, 32'h8);
        rd(4'd0, d, ds); chk("R2 set timer 3 only", d, 32'h0001_80FE);
        wr(4'd1, 32'h0);
        wr(4'd2, 32'h0);
        rd(4'd0, d, ds); chk("R2 R3 zero writes change nothing", d, 32'h0001_80FE);
    endtask

    task automatic t_ctrl();
        logic [31:0] d, ds;
        wr(4'd8, 32'hFFFF_FF09);
        rd(4'd8, d, ds);
        chk("R5 ctrl keeps six low bits", d, 32'h09);
    endtask

    task automatic t_prescale();
        snap(); strobe(3'b001, 3);
        chk("R10 div4 no strobe after 3", 32'(tc0 - b0), 0);
        strobe(3'b001, 1);
        chk("R10 div4 strobe after 4th", 32'(tc0 - b0), 1);
        wr(4'd8, 32'h01);
        snap(); strobe(3'b001, 5);
        chk("R9 div1 passes every strobe", 32'(tc0 - b0), 5);
        wr(4'd8, 32'h11);
        snap(); strobe(3'b001, 32);
        chk("R9 div16 two strobes in 32", 32'(tc0 - b0), 2);
        wr(4'd8, 32'h39);
        snap(); strobe(3'b001, 1023);
        chk("R9 code7 none after 1023", 32'(tc0 - b0), 0);
        strobe(3'b001, 1);
        chk("R9 code7 one after 1024", 32'(tc0 - b0), 1);
        wr(4'd8, 32'h29);
        snap(); strobe(3'b001, 1024);
        chk("R9 code5 one per 1024", 32'(tc0 - b0), 1);
    endtask

    task automatic t_source();
        logic [31:0] d, ds;
        wr(4'd8, 32'h06);
        snap(); strobe(3'b100, 3);
        chk("R7 ext ignored when rtc also selected", 32'(tc0 - b0), 0);
        strobe(3'b010, 3);
        chk("R7 rtc wins over ext", 32'(tc0 - b0), 3);
        wr(4'd8, 32'h07);
        snap(); strobe(3'b110, 2);
        chk("R7 pclk wins, rtc/ext ignored", 32'(tc0 - b0), 0);
        strobe(3'b001, 2);
        chk("R7 pclk counted", 32'(tc0 - b0), 2);
        wr(4'd8, 32'h04);
        snap(); strobe(3'b100, 2);
        chk("R7 ext alone", 32'(tc0 - b0), 2);
        wr(4'd8, 32'h00);
        snap(); strobe(3'b111, 4);
        chk("R8 no source bit no strobe", 32'(tc0 - b0), 0);
        rd(4'd8, d, ds);
        chk("R8 ctrl reads empty select", d, 0);
    endtask

    task automatic t_restart();
        wr(4'd8, 32'h09);
        snap(); strobe(3'b001, 3);
        wr(4'd8, 32'h0B);
        strobe(3'b001, 3);
        chk("R11 ctrl change discards count", 32'(tc0 - b0), 0);
        strobe(3'b001, 1);
        chk("R11 full period after ctrl change", 32'(tc0 - b0), 1);
        snap(); strobe(3'b001, 2);
        wr(4'd1, 32'h1);
        strobe(3'b001, 6);
        chk("R10 stopped channel silent", 32'(tc0 - b0), 0);
        wr(4'd2, 32'h1);
        strobe(3'b001, 3);
        chk("R11 restart after start", 32'(tc0 - b0), 0);
        strobe(3'b001, 1);
        chk("R11 full period after start", 32'(tc0 - b0), 1);
    endtask

    task automatic t_wdt_ost();
        logic [31:0] d, ds;
        wr(4'd2, 32'h1_0000);
        wr(4'd3, 32'h02);
        rd(4'd3, d, ds); chk("R5 watchdog ctrl at 3", d, 32'h02);
        rd(4'd0, d, ds); chk("R4 watchdog bit 16 running", d, 32'h0000_80FE);
        snap(); strobe(3'b010, 2);
        chk("R4 watchdog strobes", 32'(wc - bw), 2);
        chk("R4 OS timer still stopped", 32'(oc - bo), 0);
        wr(4'd2, 32'h8000);
        wr(4'd4, 32'h04);
        rd(4'd0, d, ds); chk("R4 OS timer bit 15 running", d, 32'h0000_00FE);
        snap(); strobe(3'b100, 3);
        chk("R5 OS timer ctrl at 4 ext", 32'(oc - bo), 3);
        chk("R7 watchdog ignores ext", 32'(wc - bw), 0);
    endtask

    task automatic t_idle_read();
        @(negedge clk);
        rd_en = 1'b0; addr = 4'd0;
        #1;
        chk("R4 rdata zero without rd_en", rdata, 0);
    endtask

    task automatic t_small();
        logic [31:0] d, ds;
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd0, d, ds); chk("R12 small all cleared", ds, 0);
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd0, d, ds); chk("R12 small bit 15 stays 0", ds, 32'h0001_003F);
        chk("R12 small ost_tick never rose", 32'(soc), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_locked();
        t_stopbits();
        t_ctrl();
        t_prescale();
        t_source();
        t_restart();
        t_wdt_ost();
        t_idle_read();
        t_small();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule